// File: doc/BRIEF.md
# Fixed-Coefficient Transposed FIR Filter

This block filters a stream of signed samples with a set of integer coefficients fixed at elaboration. A sample is taken on every clock edge where the enable is high. One registered product stage multiplies that sample by the magnitude of every coefficient in parallel. A chain of registered stages then folds the products together. The chain starts at the highest tap and ends at tap 0, which gives the transposed form. A stage with a negative coefficient subtracts its product. A stage with a zero coefficient has no adder and only re-registers the partial sum.

Each stage register holds exactly as many bits as the worst case of its partial sum needs. That width is the bit count of the sum of absolute coefficients from the highest tap down to that stage, plus the input width, plus one sign bit. The output port is the tap-0 stage register, so its width is the bit count of the total absolute coefficient sum plus the input width plus one.

Reset is asynchronous and active-low, and it is released through a two-flop synchronizer. The enable can be removed at elaboration, in which case every edge is an enabled edge.

Top module: `fir_transposed`

## Requirements
- R1: While reset is asserted, and after release until the first enabled sample has moved through the chain, the output reads zero.
- R2: After the enabled edge at index e, the output equals the sum over k of c[k]·x[e-1-k]. Here x[j] is the sample taken on the j-th enabled edge, samples before the first one count as zero, and the default coefficients are c = {3, -5, 0, 7, 2} for taps 0 to 4.
- R3: Negative coefficients give correctly signed results for both positive and negative input samples.
- R4: A zero-coefficient tap adds nothing to the sum. For a single unit impulse, the output sequence after the impulse is 3, -5, 0, 7, 2.
- R5: On an edge where the enable is low, no register changes and the output keeps its value.
- R6: The output width is bit_count(Σ|c[k]|) + DATA_W + 1, which is 14 bits for the defaults (Σ|c| = 17, 8-bit input).
- R7: Full-scale inputs of alternating sign (-128 and 127) are filtered exactly, with no wrap in any stage, and |y| never exceeds Σ|c|·2^(DATA_W-1).
- R8: After NTAPS+1 consecutive enabled zero samples, the output is zero.
- R9: The input value on edges where the enable is low is never taken into the filter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce | input | 1 | Sample enable (tied high internally when USE_CE = 0) |
| x | input | DATA_W | Signed input sample |
| y | output | bit_count(Σ\|c\|)+DATA_W+1 | Signed filtered output, from the tap-0 stage register |

## Verification
The bench feeds a unit impulse and checks that the coefficients come out in tap order with the zero tap in place. A design that added at the zero tap, reversed the chain or used the wrong latency shows up as a wrong or shifted sequence. Full-scale alternating input pushes every stage to its largest partial sum, so a stage register sized one bit too small wraps and flips the sign of the output. Negative steps exercise the subtract path, where a wrong sign extension of the product appears at once. Enable gaps carry junk on the input. A design that samples or shifts on a disabled edge either changes the output during the gap or mixes the junk into later results.

// File: rtl/fir_pkg.sv
package fir_pkg;

  localparam int COEF_W   = 16;
  localparam int MAX_TAPS = 64;
  localparam int VEC_W    = COEF_W * MAX_TAPS;

  typedef enum logic [1:0] {
    STG_ADD,
    STG_SUB,
    STG_PASS
  } stage_op_e;

  // signed coefficient of tap i from the packed vector (tap 0 in the low bits)
  function automatic int coef_at(input logic [VEC_W-1:0] vec, input int i);
    logic signed [COEF_W-1:0] c;
    c = vec[i*COEF_W +: COEF_W];
    return int'(c);
  endfunction

  function automatic int abs_int(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // sum of |c[j]| for j in [lo, n)
  function automatic int abs_sum(input logic [VEC_W-1:0] vec, input int lo, input int n);
    int s;
    s = 0;
    for (int j = lo; j < n; j++) s += abs_int(coef_at(vec, j));
    return s;
  endfunction

  function automatic int max_abs(input logic [VEC_W-1:0] vec, input int n);
    int m;
    m = 0;
    for (int j = 0; j < n; j++) if (abs_int(coef_at(vec, j)) > m) m = abs_int(coef_at(vec, j));
    return m;
  endfunction

  // number of bits needed to hold a non-negative value (0 -> 0)
  function automatic int bit_count(input int v);
    int n;
    int t;
    n = 0;
    t = v;
    for (int k = 0; k < 32; k++) begin
      if (t != 0) begin
        n++;
        t = t >> 1;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/fir_rst_sync.sv
module fir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/fir_product_stage.sv
module fir_product_stage
  import fir_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter int                NTAPS  = 5,
  parameter int                PROD_W = 12,
  parameter logic [VEC_W-1:0]  COEFS  = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] x,
  output logic signed [PROD_W-1:0] prod [NTAPS]
);

  logic signed [PROD_W-1:0] x_ext;
  assign x_ext = PROD_W'(x);

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    localparam int MAG = abs_int(coef_at(COEFS, i));

    if (MAG == 0) begin : g_zero
      assign prod[i] = '0;
    end else begin : g_mul
      localparam logic signed [PROD_W-1:0] MAG_V = PROD_W'(MAG);
      logic signed [PROD_W-1:0] prod_d, prod_q;

      always_comb begin
        prod_d = prod_q;
        if (en) prod_d = x_ext * MAG_V;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= prod_d;
      end

      assign prod[i] = prod_q;
    end
  end

endmodule

// File: rtl/fir_accum_stage.sv
module fir_accum_stage
  import fir_pkg::*;
#(
  parameter int        CHAIN_W = 14,
  parameter int        PROD_W  = 12,
  parameter int        STG_W   = 11,
  parameter stage_op_e OP      = STG_ADD
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic signed [PROD_W-1:0]  prod,
  input  logic signed [CHAIN_W-1:0] prev,
  output logic signed [CHAIN_W-1:0] sum_o
);

  logic signed [CHAIN_W-1:0] full;
  logic signed [STG_W-1:0]   acc_d, acc_q;

  if (OP == STG_ADD) begin : g_add
    assign full = prev + CHAIN_W'(prod);
  end else if (OP == STG_SUB) begin : g_sub
    assign full = prev - CHAIN_W'(prod);
  end else begin : g_pass
    logic prod_unused;
    assign prod_unused = ^prod;
    assign full = prev;
  end

  if (CHAIN_W > STG_W) begin : g_trim
    logic hi_unused;
    assign hi_unused = ^full[CHAIN_W-1:STG_W];
  end

  // limit to this stage's width, hold when not enabled
  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = full[STG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign sum_o = CHAIN_W'(acc_q);

endmodule

// File: rtl/fir_transposed.sv
module fir_transposed
  import fir_pkg::*;
#(
  parameter int               DATA_W = 8,
  parameter int               NTAPS  = 5,
  parameter logic [VEC_W-1:0] COEFS  = {16'sd2, 16'sd7, 16'sd0, -16'sd5, 16'sd3},
  parameter bit               USE_CE = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce,
  input  logic signed [DATA_W-1:0] x,
  output logic signed [bit_count(abs_sum(COEFS, 0, NTAPS))+DATA_W:0] y
);

  localparam int OUT_W  = bit_count(abs_sum(COEFS, 0, NTAPS)) + DATA_W + 1;
  localparam int PROD_W = bit_count(max_abs(COEFS, NTAPS)) + DATA_W + 1;

  logic                     rst_n_sync;
  logic                     en;
  logic signed [PROD_W-1:0] prod  [NTAPS];
  logic signed [OUT_W-1:0]  chain [NTAPS+1];

  assign en = USE_CE ? ce : 1'b1;

  fir_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  fir_product_stage #(
    .DATA_W (DATA_W),
    .NTAPS  (NTAPS),
    .PROD_W (PROD_W),
    .COEFS  (COEFS)
  ) u_prod (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .en    (en),
    .x     (x),
    .prod  (prod)
  );

  assign chain[NTAPS] = '0;

  // chain runs from the highest tap toward tap 0
  for (genvar k = 0; k < NTAPS; k++) begin : g_stage
    localparam int        CK = coef_at(COEFS, k);
    localparam int        WK = bit_count(abs_sum(COEFS, k, NTAPS)) + DATA_W + 1;
    localparam stage_op_e OK = (CK == 0) ? STG_PASS : ((CK < 0) ? STG_SUB : STG_ADD);

    fir_accum_stage #(
      .CHAIN_W (OUT_W),
      .PROD_W  (PROD_W),
      .STG_W   (WK),
      .OP      (OK)
    ) u_acc (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .en    (en),
      .prod  (prod[k]),
      .prev  (chain[k+1]),
      .sum_o (chain[k])
    );
  end

  assign y = chain[0];

endmodule

// File: rtl/fir_transposed_chk.sv
module fir_transposed_chk #(
  parameter int DATA_W    = 8,
  parameter int OUT_W     = 14,
  parameter int NTAPS     = 5,
  parameter int TOTAL_ABS = 17,
  parameter bit USE_CE    = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ce,
  input logic signed [DATA_W-1:0] x,
  input logic signed [OUT_W-1:0]  y
);

  localparam int LIMIT  = TOTAL_ABS * (2 ** (DATA_W - 1));
  localparam int CNT_W  = $clog2(NTAPS + 2) + 1;
  localparam int FLUSH  = NTAPS + 1;

  logic             en;
  logic [CNT_W-1:0] zero_run;

  assign en = USE_CE ? ce : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_run <= '0;
    end else if (en) begin
      if (x != '0) zero_run <= '0;
      else if (int'(zero_run) < FLUSH) zero_run <= zero_run + 1'b1;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> (y == '0)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(y) <= LIMIT) && (int'(y) >= -LIMIT)); // R7

  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(zero_run) >= FLUSH) |-> (y == '0)); // R8

  if (USE_CE) begin : g_ce
    AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(y)); // R5
  end

endmodule

bind fir_transposed fir_transposed_chk #(
  .DATA_W    (DATA_W),
  .OUT_W     ($bits(y)),
  .NTAPS     (NTAPS),
  .TOTAL_ABS (fir_pkg::abs_sum(COEFS, 0, NTAPS)),
  .USE_CE    (USE_CE)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ce    (ce),
  .x     (x),
  .y     (y)
);

// File: tb/fir_transposed_tb.sv
module fir_transposed_tb;

  localparam int N  = 5;
  localparam int DW = 8;
  localparam int OW = 14;

  typedef struct {
    int    val;
    string tag;
  } exp_t;

  int coef [N] = '{3, -5, 0, 7, 2};

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 ce;
  logic signed [DW-1:0] x;
  logic signed [OW-1:0] y;

  int   hist [N];
  exp_t q [$];
  int   checks = 0;
  int   errors = 0;
  logic en_seen = 1'b0;
  logic started = 1'b0;
  logic signed [OW-1:0] prev_y;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  fir_transposed u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .x     (x),
    .y     (y)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one enabled sample, expected output pushed to the scoreboard
  task automatic push(input int v, input string tag);
    exp_t e;
    @(negedge clk);
    #2;
    x  = DW'(v);
    ce = 1'b1;
    for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = int'(x);
    e.val = 0;
    for (int k = 0; k < N; k++) e.val += coef[k] * hist[k];
    e.tag = tag;
    q.push_back(e);
  endtask

  // disabled edge with junk on the input (R9)
  task automatic idle(input int v);
    @(negedge clk);
    #2;
    ce = 1'b0;
    x  = DW'(v);
  endtask

  always @(posedge clk) en_seen <= ce;

  // monitor: output after enabled edge e belongs to the sample of edge e-1
  always @(negedge clk) begin
    if (started) begin
      if (en_seen) begin
        if (q.size() >= 2) begin
          exp_t e;
          e = q.pop_front();
          check(int'(y) == e.val, e.tag, int'(y), e.val);
        end
      end else begin
        check(y == prev_y, "R5 hold", int'(y), int'(prev_y));
      end
      prev_y = y;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) hist[k] = 0;
    rst_n = 1'b0;
    ce    = 1'b0;
    x     = '0;
    repeat (3) @(negedge clk);
    check(y == '0, "R1 in reset", int'(y), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(y == '0, "R1 after release", int'(y), 0);
    check($bits(u_dut.y) == OW, "R6 width", $bits(u_dut.y), OW);
    prev_y  = y;
    started = 1'b1;

    // R4: impulse gives 3,-5,0,7,2
    push(1, "R4 impulse");
    for (int i = 0; i < 6; i++) push(0, "R4 impulse");

    // R2: positive step
    for (int i = 0; i < 8; i++) push(10, "R2 step");

    // R3: negative step
    for (int i = 0; i < 7; i++) push(-7, "R3 neg step");

    // R7: full-scale alternating
    for (int i = 0; i < 12; i++) push((i % 2) ? 127 : -128, "R7 full scale");

    // R8: flush, then junk on disabled edges (R9)
    for (int i = 0; i < N + 1; i++) push(0, "R8 flush");
    idle(55);
    idle(-99);
    #3;
    check(y == '0, "R8 R9 flushed", int'(y), 0);

    // R5, R9: enable gaps carrying junk
    begin
      logic [7:0] lfsr;
      lfsr = 8'hA5;
      for (int i = 0; i < 30; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        push(int'($signed(lfsr)), "R2 R9 pattern");
        if (i % 3 == 2) begin
          idle(int'($signed(~lfsr)));
          idle(-128);
        end
      end
    end

    for (int i = 0; i < N + 1; i++) push(0, "R8 final flush");
    idle(0);
    idle(0);
    #3;
    check(y == '0, "R8 final", int'(y), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule